// File: doc/BRIEF.md
# Board Control Register File

A small memory-mapped register block that sits on a 32-bit word bus and gives software a handful of board-level controls. It drives an eight-lamp indicator bar and an eight-character text display. It holds a break/reset configuration byte and a general-purpose output byte. It can raise a one-cycle system reset request, and it bit-bangs a two-wire serial bus through plain registers. It also returns fixed readbacks for board switches, jumpers and an endianness status word.

The display buffer can be loaded one character at a time. It can also be loaded from a single 32-bit word, which the block turns into eight uppercase hexadecimal digits. Reads are combinational from the current address. Writes take effect at the clock edge on which `wr_en` is high.

Top module: `board_ctl_regs`

## Requirements
- R1: Only address bits 19:0 are decoded, so any values in bits 31:20 select the same register.
- R2: The switch (0x200) and jumper (0x210) registers read as zero and ignore writes. The status register (0x208) reads 0x12 when `big_endian` is 1 and 0x10 when it is 0.
- R3: The lamp register (0x408), break/reset byte (0x508) and general output (0xA00) keep write data bits 7:0. The line-enable register (0xB08) keeps bits 1:0. The select register (0xB18) keeps bit 0. The line-out register (0xB10) keeps all 32 bits. Each register reads back what it kept, zero-extended.
- R4: A write to 0x410 sets display position k (k = 0..7) to the uppercase ASCII hex digit of write-data nibble 7−k, so bits 31:28 land in position 0. Position k appears on `disp[8k+7:8k]`.
- R5: A write to 0x418 + 8·n (n = 0..7) stores write data bits 7:0 in display position n and leaves the other positions unchanged.
- R6: A write of exactly 0x42 to 0x500 makes `rst_req` high for one cycle, in the cycle after the write. Any other value, or 0x42 written to any other address, leaves `rst_req` low.
- R7: The general input register (0xA08) returns the line-out word when the select bit is 1, and returns zero when it is 0.
- R8: The line-in register (0xB00) reads as 0x2 with bit 0 replaced by the live `sda_in` level.
- R9: `scl` follows bit 1 and `sda` follows bit 0 of the line-out register.
- R10: After reset: lamps 0x00, break/reset 0x0A, general output 0x00, line enable 0x0, line out 0x3, select 0x1, every display position 0x20, and `rst_req` low.
- R11: Undecoded offsets read zero. Writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| big_endian | input | 1 | Endianness strap reflected in the status register |
| addr | input | 32 | Bus address (bits 19:0 decoded) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` |
| sda_in | input | 1 | Data level returned by the attached serial device |
| leds | output | 8 | Lamp bar |
| disp | output | 64 | Display buffer, position k in bits 8k+7:8k |
| rst_req | output | 1 | One-cycle reset request |
| scl | output | 1 | Serial clock level |
| sda | output | 1 | Serial data level |

## Verification
The hardest case to reach is the reset request, because it must be shown both to fire and to stay quiet. The stimulus sends 0x42 to the reset address and samples `rst_req` in the following cycle and again one cycle later. It then sends a near-miss value (0x43) to the reset address, and 0x42 to the neighbouring break/reset address, checking that no pulse appears in either case. The hex-word path is driven with two words whose nibbles together cover both the digit and the letter ranges.

// File: rtl/board_ctl_regs.sv
module board_ctl_regs #(
  parameter int DW    = 32,
  parameter int DEC_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_endian,
  input  logic [31:0]       addr,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  input  logic              sda_in,
  output logic [7:0]        leds,
  output logic [8*(DW/4)-1:0] disp,
  output logic              rst_req,
  output logic              scl,
  output logic              sda
);
  localparam int NPOS = DW / 4;
  localparam logic [DEC_W-1:0] A_SWITCH = 'h200, A_STATUS = 'h208, A_JUMPER = 'h210,
    A_LAMP = 'h408, A_HEXW = 'h410, A_POS0 = 'h418, A_POSN = 'h418 + 8 * (NPOS - 1),
    A_RESTART = 'h500, A_TRAP = 'h508, A_AUXO = 'hA00, A_AUXI = 'hA08,
    A_LIN = 'hB00, A_LOE = 'hB08, A_LOUT = 'hB10, A_LSEL = 'hB18;
  localparam logic [7:0] SPACE = 8'h20, KICK = 8'h42;

  logic [DEC_W-1:0] off, pos_off;
  logic [7:0]       lamp_q, trap_q, aux_q;
  logic [1:0]       oe_q;
  logic             sel_q;
  logic [DW-1:0]    line_q;
  logic [7:0]       chars_q [NPOS];
  logic             is_pos;

  function automatic logic [7:0] hexchar(input logic [3:0] n);
    return (n < 4'd10) ? 8'h30 + {4'h0, n} : 8'h37 + {4'h0, n};
  endfunction

  assign off     = addr[DEC_W-1:0];
  assign pos_off = off - A_POS0;
  assign is_pos  = (off >= A_POS0) && (off <= A_POSN) && (off[2:0] == 3'b000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lamp_q  <= '0;
      trap_q  <= 8'h0A;
      aux_q   <= '0;
      oe_q    <= '0;
      sel_q   <= 1'b1;
      line_q  <= DW'(3);
      rst_req <= 1'b0;
      for (int k = 0; k < NPOS; k++) chars_q[k] <= SPACE;
    end else begin
      rst_req <= wr_en && (off == A_RESTART) && (wr_data == DW'(KICK));
      if (wr_en) begin
        case (off)
          A_LAMP: lamp_q <= wr_data[7:0];
          A_TRAP: trap_q <= wr_data[7:0];
          A_AUXO: aux_q  <= wr_data[7:0];
          A_LOE:  oe_q   <= wr_data[1:0];
          A_LSEL: sel_q  <= wr_data[0];
          A_LOUT: line_q <= wr_data;
          A_HEXW:
            for (int k = 0; k < NPOS; k++)
              chars_q[k] <= hexchar(wr_data[DW-1-4*k -: 4]);
          default:
            if (is_pos) chars_q[pos_off[5:3]] <= wr_data[7:0];
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (off)
      A_SWITCH, A_JUMPER: rd_data = '0;
      A_STATUS: rd_data = big_endian ? DW'(8'h12) : DW'(8'h10);
      A_LAMP:   rd_data = DW'(lamp_q);
      A_TRAP:   rd_data = DW'(trap_q);
      A_AUXO:   rd_data = DW'(aux_q);
      A_AUXI:   rd_data = sel_q ? line_q : '0;
      A_LIN:    rd_data = DW'({1'b1, sda_in});
      A_LOE:    rd_data = DW'(oe_q);
      A_LOUT:   rd_data = line_q;
      A_LSEL:   rd_data = DW'(sel_q);
      default:  rd_data = '0;
    endcase
  end

  for (genvar g = 0; g < NPOS; g++) begin : g_disp
    assign disp[8*g +: 8] = chars_q[g];
  end

  assign leds = lamp_q;
  assign scl  = line_q[1];
  assign sda  = line_q[0];
endmodule

// File: rtl/board_ctl_regs_chk.sv
module board_ctl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        big_endian,
  input logic [31:0] addr,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic [7:0]  leds,
  input logic [63:0] disp,
  input logic        rst_req,
  input logic        scl,
  input logic        sda
);
  function automatic logic [7:0] digit(input logic [3:0] n);
    return (n < 4'd10) ? 8'h30 + {4'h0, n} : 8'h41 + {4'h0, n} - 8'd10;
  endfunction

  assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(wr_en && addr[19:0] == 20'h500 && wr_data == 32'h42));
  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req || $past(wr_en && addr[19:0] == 20'h500, 1));
  assert_lamp_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[19:0] == 20'h408) |=> leds == $past(wr_data[7:0]));
  assert_hex_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[19:0] == 20'h410) |=> disp[7:0] == digit($past(wr_data[31:28])));
  assert_hex_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[19:0] == 20'h410) |=> disp[63:56] == digit($past(wr_data[3:0])));
  assert_line_pins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[19:0] == 20'hB10) |-> rd_data[1:0] == {scl, sda});
  assert_fixed_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[19:0] == 20'h200 || addr[19:0] == 20'h210) |-> rd_data == 32'h0);
  assert_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[19:0] == 20'h208) |-> rd_data == (big_endian ? 32'h12 : 32'h10));
endmodule

bind board_ctl_regs board_ctl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .addr(addr),
  .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .leds(leds),
  .disp(disp), .rst_req(rst_req), .scl(scl), .sda(sda)
);

// File: tb/board_ctl_regs_tb.sv
`timescale 1ns/1ps
module board_ctl_regs_tb;
  logic        clk = 0, rst_n = 0, big_endian = 1, wr_en = 0, sda_in = 1;
  logic [31:0] addr = 0, wr_data = 0, rd_data;
  logic [7:0]  leds;
  logic [63:0] disp;
  logic        rst_req, scl, sda;
  int checks = 0, failures = 0;
  logic        rd_chk = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  board_ctl_regs u_dut (.clk(clk), .rst_n(rst_n), .big_endian(big_endian), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .sda_in(sda_in), .leds(leds),
    .disp(disp), .rst_req(rst_req), .scl(scl), .sda(sda));

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rd_chk && exp_q.size() > 0)
    check(tag_q.pop_front(), {32'h0, rd_data}, {32'h0, exp_q.pop_front()});

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    addr = a; wr_data = d; wr_en = 1;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    addr = a; exp_q.push_back(e); tag_q.push_back(tag); rd_chk = 1;
    @(posedge clk); #1;
    rd_chk = 0;
  endtask

  task automatic finish_up;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check("R10 leds", {56'h0, leds}, 64'h0);
    check("R10 disp", disp, 64'h2020202020202020);
    check("R10 rst_req", {63'h0, rst_req}, 64'h0);
    check("R10 scl/sda", {62'h0, scl, sda}, 64'h3);
    rd(32'h508, 32'h0A, "R10 trap");
    rd(32'hA00, 32'h0, "R10 aux out");
    rd(32'hB08, 32'h0, "R10 line enable");
    rd(32'hB10, 32'h3, "R10 line out");
    rd(32'hB18, 32'h1, "R10 select");
    rd(32'hA08, 32'h3, "R10 aux in");

    rd(32'h200, 32'h0, "R2 switch");
    rd(32'h210, 32'h0, "R2 jumper");
    rd(32'h208, 32'h12, "R2 status big");
    big_endian = 0;
    rd(32'h208, 32'h10, "R2 status little");
    wr(32'h200, 32'hFFFFFFFF);
    wr(32'h210, 32'hFFFFFFFF);
    rd(32'h200, 32'h0, "R2 switch after write");
    rd(32'h210, 32'h0, "R2 jumper after write");

    wr(32'h408, 32'h123456A5);
    check("R3 leds", {56'h0, leds}, 64'hA5);
    rd(32'h408, 32'hA5, "R3 lamp read");
    wr(32'h508, 32'hFFFFFF3C);
    rd(32'h508, 32'h3C, "R3 trap");
    wr(32'hA00, 32'h1FF);
    rd(32'hA00, 32'hFF, "R3 aux out");
    wr(32'hB08, 32'hFF);
    rd(32'hB08, 32'h3, "R3 line enable");
    wr(32'hB18, 32'hFE);
    rd(32'hB18, 32'h0, "R3 select");
    wr(32'hB18, 32'h3);
    rd(32'hB18, 32'h1, "R3 select set");

    wr(32'h410, 32'h0123ABCD);
    check("R4 hex word a", disp, 64'h4443424133323130);
    wr(32'h410, 32'hFEDC9870);
    check("R4 hex word b", disp, 64'h303738394344_4546);

    wr(32'h430, 32'h1234567A);
    check("R5 position 3", disp, 64'h303738397A444546);
    wr(32'h450, 32'h21);
    check("R5 position 7", disp, 64'h213738397A444546);
    wr(32'h418, 32'h5F);
    check("R5 position 0", disp, 64'h213738397A44455F);

    wr(32'h500, 32'h43);
    check("R6 near miss", {63'h0, rst_req}, 64'h0);
    wr(32'h508, 32'h42);
    check("R6 wrong address", {63'h0, rst_req}, 64'h0);
    wr(32'h500, 32'h42);
    check("R6 pulse high", {63'h0, rst_req}, 64'h1);
    @(posedge clk); #1;
    check("R6 pulse ends", {63'h0, rst_req}, 64'h0);

    wr(32'hB10, 32'h5A5A5A5A);
    wr(32'hB18, 32'h0);
    rd(32'hA08, 32'h0, "R7 aux in gated");
    wr(32'hB18, 32'h1);
    rd(32'hA08, 32'h5A5A5A5A, "R7 aux in open");
    rd(32'hB10, 32'h5A5A5A5A, "R3 line out full word");

    wr(32'hB10, 32'h2);
    check("R9 scl1 sda0", {62'h0, scl, sda}, 64'h2);
    wr(32'hB10, 32'h1);
    check("R9 scl0 sda1", {62'h0, scl, sda}, 64'h1);

    sda_in = 0;
    rd(32'hB00, 32'h2, "R8 line in low");
    sda_in = 1;
    rd(32'hB00, 32'h3, "R8 line in high");

    wr(32'hFFF00408, 32'h77);
    check("R1 alias write", {56'h0, leds}, 64'h77);
    rd(32'h12300408, 32'h77, "R1 alias read");

    rd(32'h404, 32'h0, "R11 undefined read");
    rd(32'h600, 32'h0, "R11 undefined read 2");
    wr(32'h40C, 32'hFF);
    check("R11 leds untouched", {56'h0, leds}, 64'h77);
    wr(32'h414, 32'h41414141);
    check("R11 disp untouched", disp, 64'h213738397A44455F);
    wr(32'h41C, 32'h41);
    check("R11 odd offset ignored", disp, 64'h213738397A44455F);

    repeat (2) @(posedge clk);
    finish_up();
  end
endmodule